// File: doc/BRIEF.md
# Configuration Frame Scrub Controller

This block keeps a frame-organised configuration memory free of bit upsets. Each frame is 101 words of 32 bits. A host command switches the controller between a passive mode and a watching mode. In the passive mode the host can plant a test fault: the controller reads a whole frame, inverts one chosen bit of one chosen word, and writes the frame back. In the watching mode the controller listens to two detectors, both of which sit outside the block. The first is a per-frame error-correcting check that gives a 13-bit syndrome and the frame's physical address. The second is a pass-level CRC verdict that arrives at the end of each background readback.

Repair works at two granularities. A nonzero syndrome names the bad frame, so only that frame is rewritten from the golden copy in external memory. A CRC failure with no syndrome hit in the same pass names no frame, so every frame is rewritten. Physical frame addresses are turned into a linear frame index through a small table of column base offsets. The golden word for a frame sits at linear index × 101 + word. Both memories are reached through single-word request/acknowledge ports.

Top module: `scrub_ctrl`

## Requirements
- R1: After reset the block is in passive mode (`mode_obs`=0) with `busy`, `done`, `fm_req` and `gm_req` low and `repair_code` = 00.
- R2: With `cmd_valid` high and `busy` low, `cmd_op` selects the action: 01 enters passive mode, 10 enters watching mode, 11 requests a fault injection, 00 does nothing. A command given while `busy` is high is dropped.
- R3: An injection in passive mode reads words 0..100 of the addressed frame and then writes words 0..100 back, with only bit `cmd_bit` of word `cmd_word` inverted. When it finishes, `done` pulses with `repair_code` 00. In watching mode an injection command is ignored: the memory is untouched and `busy` stays low.
- R4: A physical address carries the frame-within-column in bits [6:0] and the column in bits [8:7]; all higher bits are ignored. The linear index is COL_BASE[column] + frame-within-column (default bases 0, 8, 16, 24). During a repair, the golden address read for a word is linear × 101 + word.
- R5: In watching mode, `ecc_valid` with a nonzero `ecc_syndrome` rewrites only the frame at `ecc_far`. Each of its 101 words, including the check word at index 50, is read from golden memory and then written, and `done` pulses with code 01. A zero syndrome starts nothing.
- R6: In watching mode, `crc_done` with `crc_err` rewrites all frames 0..NUM_FRAMES-1 and ends with `done` and code 10. This happens only if no nonzero syndrome was seen since the previous `crc_done` or since watching mode was entered; otherwise the CRC failure is ignored.
- R7: In passive mode, syndrome and CRC inputs have no effect.
- R8: A syndrome error that arrives while a repair runs, including in the cycle the repair ends, is held. Its single-frame repair starts on the same edge that raises the current `done`, so `busy` stays high.
- R9: If a detector hit and a command arrive in the same idle cycle, the repair starts and the command is dropped.
- R10: Each memory request holds its address, word index and direction steady until acknowledged. Words are visited in ascending order within a frame, and the two ports never request at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | Command code (00 none, 01 passive, 10 watch, 11 inject) |
| cmd_pfa | input | 26 | Physical frame address for injection |
| cmd_word | input | 7 | Word to disturb |
| cmd_bit | input | 5 | Bit to invert |
| ecc_valid | input | 1 | Syndrome strobe for one frame |
| ecc_syndrome | input | 13 | Frame check syndrome |
| ecc_far | input | 26 | Physical address of the checked frame |
| crc_done | input | 1 | End of a readback pass |
| crc_err | input | 1 | Pass CRC mismatch |
| fm_req | output | 1 | Frame memory request |
| fm_we | output | 1 | Frame memory write (1) / read (0) |
| fm_frame | output | 5 | Linear frame index |
| fm_word | output | 7 | Word within frame |
| fm_wdata | output | 32 | Write data |
| fm_ack | input | 1 | Frame memory acknowledge |
| fm_rdata | input | 32 | Read data, valid with ack |
| gm_req | output | 1 | Golden memory read request |
| gm_addr | output | 12 | Golden word address |
| gm_ack | input | 1 | Golden memory acknowledge |
| gm_rdata | input | 32 | Golden data, valid with ack |
| busy | output | 1 | An injection or repair is running |
| mode_obs | output | 1 | Watching mode active |
| done | output | 1 | One-cycle end-of-operation pulse |
| repair_code | output | 2 | Kind of finished operation: 00 none, 01 frame, 10 full |

## Verification
The delicate overlap is a fresh syndrome hit landing in the very cycle that a single-frame repair acknowledges its final word. The bench waits until the last write of a repair is requested but not yet acknowledged, then raises a syndrome for a second corrupted frame. It judges the result by seeing `done` with code 01 while `busy` stays high in the same cycle, then a second completion, and finally a frame memory identical to the golden image. A second overlap, a command arriving together with a syndrome hit, is judged by the repair running while the mode stays unchanged.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INJ_RD,
        ST_INJ_WR,
        ST_REP_GRD,
        ST_REP_WR
    } scrub_st_e;

    localparam logic [1:0] OP_NONE  = 2'b00;
    localparam logic [1:0] OP_IDLE  = 2'b01;
    localparam logic [1:0] OP_WATCH = 2'b10;
    localparam logic [1:0] OP_INJ   = 2'b11;

    localparam logic [1:0] RC_NONE   = 2'b00;
    localparam logic [1:0] RC_SINGLE = 2'b01;
    localparam logic [1:0] RC_FULL   = 2'b10;

endpackage

// File: rtl/scrub_frame_map.sv
module scrub_frame_map #(
    parameter int NUM_FRAMES = 32,
    parameter int NUM_COLS   = 4,
    parameter int MINOR_W    = 7,
    parameter int PFA_W      = 26,
    parameter int LIN_W      = 5,
    parameter logic [NUM_COLS*LIN_W-1:0] COL_BASE = {5'd24, 5'd16, 5'd8, 5'd0}
) (
    input  logic [PFA_W-1:0] pfa,
    output logic [LIN_W-1:0] lin
);
    localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
    localparam int SUM_W = LIN_W + MINOR_W;

    logic [COL_W-1:0]   col;
    logic [MINOR_W-1:0] minor;
    logic [LIN_W-1:0]   base;
    logic [SUM_W-1:0]   sum;

    always_comb begin
        col   = pfa[MINOR_W +: COL_W];
        minor = pfa[MINOR_W-1:0];
        base  = COL_BASE[col*LIN_W +: LIN_W];
        sum   = {{MINOR_W{1'b0}}, base} + {{LIN_W{1'b0}}, minor};
        lin   = sum[LIN_W-1:0];
    end
endmodule

// File: rtl/scrub_frame_buf.sv
module scrub_frame_buf #(
    parameter int DEPTH = 101,
    parameter int WIDTH = 32,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[widx] <= wdata;
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
    import scrub_pkg::*;
#(
    parameter int NUM_FRAMES = 32,
    parameter int WPF        = 101,
    parameter int WORD_W     = 32,
    parameter int NUM_COLS   = 4,
    parameter int MINOR_W    = 7,
    parameter int PFA_W      = 26,
    parameter int SYN_W      = 13,
    parameter int LIN_W      = $clog2(NUM_FRAMES),
    parameter int WIDX_W     = $clog2(WPF),
    parameter int BIT_W      = $clog2(WORD_W),
    parameter int GA_W       = $clog2(NUM_FRAMES * WPF),
    parameter logic [NUM_COLS*LIN_W-1:0] COL_BASE = {5'd24, 5'd16, 5'd8, 5'd0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PFA_W-1:0]  cmd_pfa,
    input  logic [WIDX_W-1:0] cmd_word,
    input  logic [BIT_W-1:0]  cmd_bit,
    input  logic              ecc_valid,
    input  logic [SYN_W-1:0]  ecc_syndrome,
    input  logic [PFA_W-1:0]  ecc_far,
    input  logic              crc_done,
    input  logic              crc_err,
    output logic              fm_req,
    output logic              fm_we,
    output logic [LIN_W-1:0]  fm_frame,
    output logic [WIDX_W-1:0] fm_word,
    output logic [WORD_W-1:0] fm_wdata,
    input  logic              fm_ack,
    input  logic [WORD_W-1:0] fm_rdata,
    output logic              gm_req,
    output logic [GA_W-1:0]   gm_addr,
    input  logic              gm_ack,
    input  logic [WORD_W-1:0] gm_rdata,
    output logic              busy,
    output logic              mode_obs,
    output logic              done,
    output logic [1:0]        repair_code
);
    localparam logic [WIDX_W-1:0] LAST_WORD  = WIDX_W'(WPF - 1);
    localparam logic [LIN_W-1:0]  LAST_FRAME = LIN_W'(NUM_FRAMES - 1);

    typedef struct packed {
        scrub_st_e          st;
        logic               mode;
        logic [LIN_W-1:0]   frame;
        logic [WIDX_W-1:0]  word;
        logic               full;
        logic [1:0]         kind;
        logic [1:0]         out_code;
        logic               done;
        logic               fm_req;
        logic               fm_we;
        logic               gm_req;
        logic [WORD_W-1:0]  gdata;
        logic [WIDX_W-1:0]  inj_word;
        logic [BIT_W-1:0]   inj_bit;
        logic               pend_syn;
        logic [LIN_W-1:0]   pend_frame;
        logic               pend_full;
        logic               syn_seen;
    } regs_t;

    regs_t r_q, r_d;

    logic [LIN_W-1:0]  far_lin, cmd_lin;
    logic [WORD_W-1:0] buf_rdata;
    logic              buf_we;
    logic              syn_hit, crc_hit, launch;

    scrub_frame_map #(
        .NUM_FRAMES(NUM_FRAMES), .NUM_COLS(NUM_COLS), .MINOR_W(MINOR_W),
        .PFA_W(PFA_W), .LIN_W(LIN_W), .COL_BASE(COL_BASE)
    ) u_map_far (.pfa(ecc_far), .lin(far_lin));

    scrub_frame_map #(
        .NUM_FRAMES(NUM_FRAMES), .NUM_COLS(NUM_COLS), .MINOR_W(MINOR_W),
        .PFA_W(PFA_W), .LIN_W(LIN_W), .COL_BASE(COL_BASE)
    ) u_map_cmd (.pfa(cmd_pfa), .lin(cmd_lin));

    scrub_frame_buf #(.DEPTH(WPF), .WIDTH(WORD_W), .IDX_W(WIDX_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (r_q.word),
        .wdata (fm_rdata),
        .ridx  (r_q.word),
        .rdata (buf_rdata)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        buf_we     = 1'b0;
        launch     = 1'b0;
        syn_hit    = r_q.mode && ecc_valid && (|ecc_syndrome);
        crc_hit    = r_q.mode && crc_done && crc_err && !r_q.syn_seen && !syn_hit;

        // a readback pass ends with crc_done; syndrome hits mark the pass
        if (r_q.mode && crc_done)  r_d.syn_seen = 1'b0;
        else if (syn_hit)          r_d.syn_seen = 1'b1;

        if (syn_hit && !r_q.pend_syn) begin
            r_d.pend_syn   = 1'b1;
            r_d.pend_frame = far_lin;
        end
        if (crc_hit) r_d.pend_full = 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (r_d.pend_syn || r_d.pend_full) begin
                    launch = 1'b1;
                end else if (cmd_valid) begin
                    unique case (cmd_op)
                        OP_IDLE:  r_d.mode = 1'b0;
                        OP_WATCH: begin
                            r_d.mode     = 1'b1;
                            r_d.syn_seen = 1'b0;
                        end
                        OP_INJ: if (!r_q.mode) begin
                            r_d.st       = ST_INJ_RD;
                            r_d.frame    = cmd_lin;
                            r_d.word     = '0;
                            r_d.fm_req   = 1'b1;
                            r_d.fm_we    = 1'b0;
                            r_d.inj_word = cmd_word;
                            r_d.inj_bit  = cmd_bit;
                        end
                        default: ;
                    endcase
                end
            end
            ST_INJ_RD: if (fm_ack) begin
                buf_we = 1'b1;
                if (r_q.word == LAST_WORD) begin
                    r_d.st    = ST_INJ_WR;
                    r_d.word  = '0;
                    r_d.fm_we = 1'b1;
                end else begin
                    r_d.word = r_q.word + 1'b1;
                end
            end
            ST_INJ_WR: if (fm_ack) begin
                if (r_q.word == LAST_WORD) begin
                    r_d.st       = ST_IDLE;
                    r_d.fm_req   = 1'b0;
                    r_d.fm_we    = 1'b0;
                    r_d.done     = 1'b1;
                    r_d.out_code = RC_NONE;
                end else begin
                    r_d.word = r_q.word + 1'b1;
                end
            end
            ST_REP_GRD: if (gm_ack) begin
                r_d.gdata  = gm_rdata;
                r_d.gm_req = 1'b0;
                r_d.fm_req = 1'b1;
                r_d.fm_we  = 1'b1;
                r_d.st     = ST_REP_WR;
            end
            ST_REP_WR: if (fm_ack) begin
                r_d.fm_req = 1'b0;
                r_d.fm_we  = 1'b0;
                if (r_q.word != LAST_WORD) begin
                    r_d.word   = r_q.word + 1'b1;
                    r_d.gm_req = 1'b1;
                    r_d.st     = ST_REP_GRD;
                end else if (r_q.full && r_q.frame != LAST_FRAME) begin
                    r_d.frame  = r_q.frame + 1'b1;
                    r_d.word   = '0;
                    r_d.gm_req = 1'b1;
                    r_d.st     = ST_REP_GRD;
                end else begin
                    r_d.done     = 1'b1;
                    r_d.out_code = r_q.kind;
                    r_d.st       = ST_IDLE;
                    launch       = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (launch) begin
            if (r_d.pend_syn) begin
                r_d.st       = ST_REP_GRD;
                r_d.frame    = r_d.pend_frame;
                r_d.word     = '0;
                r_d.full     = 1'b0;
                r_d.kind     = RC_SINGLE;
                r_d.gm_req   = 1'b1;
                r_d.pend_syn = 1'b0;
            end else if (r_d.pend_full) begin
                r_d.st        = ST_REP_GRD;
                r_d.frame     = '0;
                r_d.word      = '0;
                r_d.full      = 1'b1;
                r_d.kind      = RC_FULL;
                r_d.gm_req    = 1'b1;
                r_d.pend_full = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign fm_req      = r_q.fm_req;
    assign fm_we       = r_q.fm_we;
    assign fm_frame    = r_q.frame;
    assign fm_word     = r_q.word;
    assign fm_wdata    = (r_q.st == ST_INJ_WR) ?
                         (buf_rdata ^ ((r_q.word == r_q.inj_word) ?
                                       (WORD_W'(1) << r_q.inj_bit) : '0)) :
                         r_q.gdata;
    assign gm_req      = r_q.gm_req;
    assign gm_addr     = GA_W'(r_q.frame) * GA_W'(WPF) + GA_W'(r_q.word);
    assign busy        = (r_q.st != ST_IDLE);
    assign mode_obs    = r_q.mode;
    assign done        = r_q.done;
    assign repair_code = r_q.out_code;

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_obs));

    // R3
    inj_passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_INJ_RD || r_q.st == ST_INJ_WR) |-> !mode_obs);

    // R5
    rep_watch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REP_GRD || r_q.st == ST_REP_WR) |-> mode_obs);

    // R10
    fm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fm_req && !fm_ack) |=> (fm_req && $stable(fm_word) && $stable(fm_frame) && $stable(fm_we)));

    // R10
    gm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gm_req && !gm_ack) |=> (gm_req && $stable(gm_addr)));

    // R10
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fm_req && gm_req));

    // R6
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (repair_code != 2'b11));
endmodule

// File: tb/sim_scrub_ctrl.sv
module sim_scrub_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NF   = 32;
    localparam int WPF  = 101;
    localparam int TOT  = NF * WPF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [25:0] cmd_pfa;
    logic [6:0]  cmd_word;
    logic [4:0]  cmd_bit;
    logic        ecc_valid;
    logic [12:0] ecc_syndrome;
    logic [25:0] ecc_far;
    logic        crc_done, crc_err;
    logic        fm_req, fm_we;
    logic [4:0]  fm_frame;
    logic [6:0]  fm_word;
    logic [31:0] fm_wdata;
    logic        fm_ack;
    logic [31:0] fm_rdata;
    logic        gm_req;
    logic [11:0] gm_addr;
    logic        gm_ack;
    logic [31:0] gm_rdata;
    logic        busy, mode_obs, done;
    logic [1:0]  repair_code;

    scrub_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pfa(cmd_pfa), .cmd_word(cmd_word), .cmd_bit(cmd_bit),
        .ecc_valid(ecc_valid), .ecc_syndrome(ecc_syndrome), .ecc_far(ecc_far),
        .crc_done(crc_done), .crc_err(crc_err),
        .fm_req(fm_req), .fm_we(fm_we), .fm_frame(fm_frame), .fm_word(fm_word),
        .fm_wdata(fm_wdata), .fm_ack(fm_ack), .fm_rdata(fm_rdata),
        .gm_req(gm_req), .gm_addr(gm_addr), .gm_ack(gm_ack), .gm_rdata(gm_rdata),
        .busy(busy), .mode_obs(mode_obs), .done(done), .repair_code(repair_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [31:0] gold [TOT];
    logic [31:0] fmem [TOT];
    logic [31:0] snap [TOT];

    int n_chk = 0, n_bad = 0;
    int fm_rd_cnt, fm_wr_cnt, gm_rd_cnt, ord_err, addr_err;
    int rd_exp, wr_exp, idx, last_ga;
    bit ga_valid;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lin_of(input int col, input int minor);
        return col * 8 + minor;
    endfunction

    function automatic logic [25:0] pfa_of(input int col, input int minor, input int hi);
        return {hi[16:0], col[1:0], minor[6:0]};
    endfunction

    function automatic int mem_diffs();
        int n = 0;
        for (int i = 0; i < TOT; i++) if (fmem[i] !== gold[i]) n++;
        return n;
    endfunction

    task automatic clr_counts();
        fm_rd_cnt = 0; fm_wr_cnt = 0; gm_rd_cnt = 0; ord_err = 0; addr_err = 0;
        rd_exp = 0; wr_exp = 0; ga_valid = 0;
    endtask

    // memory models
    initial begin
        fm_ack = 0; gm_ack = 0; fm_rdata = 0; gm_rdata = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                fm_ack = 0; gm_ack = 0;
            end else begin
                if (fm_ack) fm_ack = 0;
                else if (fm_req) begin
                    idx = int'(fm_frame) * WPF + int'(fm_word);
                    if (fm_we) begin
                        if (int'(fm_word) != wr_exp) ord_err++;
                        wr_exp = (int'(fm_word) == WPF - 1) ? 0 : int'(fm_word) + 1;
                        if (ga_valid && last_ga != idx) addr_err++;
                        ga_valid = 0;
                        fmem[idx] = fm_wdata;
                        fm_wr_cnt++;
                    end else begin
                        if (int'(fm_word) != rd_exp) ord_err++;
                        rd_exp = (int'(fm_word) == WPF - 1) ? 0 : int'(fm_word) + 1;
                        fm_rdata = fmem[idx];
                        fm_rd_cnt++;
                    end
                    fm_ack = 1;
                end
                if (gm_ack) gm_ack = 0;
                else if (gm_req) begin
                    gm_rdata = gold[gm_addr];
                    last_ga  = int'(gm_addr);
                    ga_valid = 1;
                    gm_rd_cnt++;
                    gm_ack = 1;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [25:0] pfa, input int w, input int b);
        cmd_valid = 1; cmd_op = op; cmd_pfa = pfa; cmd_word = 7'(w); cmd_bit = 5'(b);
        tick();
        cmd_valid = 0;
    endtask

    task automatic pulse_ecc(input logic [25:0] pfa, input logic [12:0] syn);
        ecc_valid = 1; ecc_far = pfa; ecc_syndrome = syn;
        tick();
        ecc_valid = 0; ecc_syndrome = 0;
    endtask

    task automatic pulse_crc(input bit err);
        crc_done = 1; crc_err = err;
        tick();
        crc_done = 0; crc_err = 0;
    endtask

    task automatic wait_done(output logic [1:0] code, output bit got);
        got = 0; code = 2'b11;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin code = repair_code; got = 1; break; end
        end
    endtask

    task automatic inject(input int col, input int minor, input int w, input int b);
        logic [1:0] c; bit g;
        send_cmd(2'b11, pfa_of(col, minor, 0), w, b);
        wait_done(c, g);
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] code; bit got;
        int col, mnr, w, b, hi, lin, nd, fa, fb;
        void'($urandom(32'd4242));
        for (int i = 0; i < TOT; i++) begin gold[i] = $urandom; fmem[i] = gold[i]; end
        rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_pfa = 0; cmd_word = 0; cmd_bit = 0;
        ecc_valid = 0; ecc_syndrome = 0; ecc_far = 0; crc_done = 0; crc_err = 0;
        clr_counts();
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1
        chk(!busy && !mode_obs && !done && !fm_req && !gm_req && repair_code == 2'b00,
            "R1 reset state", {busy, mode_obs, done, fm_req, gm_req}, 0);
        tick();

        // R7: detectors in passive mode do nothing
        pulse_ecc(pfa_of(1, 2, 0), 13'h55);
        pulse_crc(1);
        repeat (3) tick();
        chk(!busy && !fm_req && !gm_req, "R7 passive ignores detectors", busy, 0);

        // R3 R4: random injections with upper address noise
        for (int k = 0; k < 6; k++) begin
            col = $urandom_range(0, 3); mnr = $urandom_range(0, 7);
            w = $urandom_range(0, WPF - 1); b = $urandom_range(0, 31);
            hi = $urandom_range(0, 131071);
            lin = lin_of(col, mnr);
            for (int i = 0; i < TOT; i++) snap[i] = fmem[i];
            clr_counts();
            send_cmd(2'b11, pfa_of(col, mnr, hi), w, b);
            wait_done(code, got);
            chk(got && code == 2'b00, "R3 injection done code", code, 0);
            nd = 0;
            for (int i = 0; i < TOT; i++) if (fmem[i] !== snap[i]) nd++;
            chk(nd == 1, "R3 one word changed", nd, 1);
            chk((fmem[lin*WPF+w] ^ snap[lin*WPF+w]) == (32'h1 << b),
                "R4 flipped bit at mapped frame", fmem[lin*WPF+w] ^ snap[lin*WPF+w], 32'h1 << b);
            chk(fm_rd_cnt == WPF && fm_wr_cnt == WPF, "R3 read then write counts", fm_rd_cnt + fm_wr_cnt, 2*WPF);
            chk(ord_err == 0, "R10 ascending word order", ord_err, 0);
            tick();
        end

        // R2: enter watching mode
        send_cmd(2'b10, 0, 0, 0);
        @(negedge clk);
        chk(mode_obs, "R2 watch command", mode_obs, 1);
        tick();
        // R3: injection ignored in watching mode
        for (int i = 0; i < TOT; i++) snap[i] = fmem[i];
        send_cmd(2'b11, pfa_of(2, 3, 0), 5, 5);
        repeat (3) tick();
        nd = 0;
        for (int i = 0; i < TOT; i++) if (fmem[i] !== snap[i]) nd++;
        chk(!busy && nd == 0, "R3 injection ignored while watching", nd, 0);

        // R6: CRC failure with no syndrome hit -> full rewrite
        clr_counts();
        pulse_crc(1);
        wait_done(code, got);
        chk(got && code == 2'b10, "R6 full rewrite code", code, 2);
        chk(mem_diffs() == 0, "R6 memory restored", mem_diffs(), 0);
        chk(fm_wr_cnt == TOT && gm_rd_cnt == TOT, "R6 rewrite word count", fm_wr_cnt, TOT);
        chk(addr_err == 0, "R4 golden address per word", addr_err, 0);
        tick();

        // R5: single frame repair on check word 50
        send_cmd(2'b01, 0, 0, 0);
        col = $urandom_range(0, 3); mnr = $urandom_range(0, 7);
        inject(col, mnr, 50, $urandom_range(0, 31));
        send_cmd(2'b10, 0, 0, 0);
        pulse_ecc(pfa_of(col, mnr, 0), 13'h0);
        repeat (3) tick();
        chk(!busy, "R5 zero syndrome ignored", busy, 0);
        clr_counts();
        pulse_ecc(pfa_of(col, mnr, 7), 13'h0A1);
        wait_done(code, got);
        chk(got && code == 2'b01, "R5 single repair code", code, 1);
        chk(mem_diffs() == 0, "R5 check word restored", mem_diffs(), 0);
        chk(fm_wr_cnt == WPF && gm_rd_cnt == WPF, "R5 only one frame written", fm_wr_cnt, WPF);
        chk(addr_err == 0 && ord_err == 0, "R4 golden address single", addr_err + ord_err, 0);
        tick();
        // R6: CRC failure in a pass that saw a syndrome hit is ignored
        pulse_crc(1);
        repeat (3) tick();
        chk(!busy, "R6 crc ignored after syndrome hit", busy, 0);

        // R8: syndrome during repair is queued
        send_cmd(2'b01, 0, 0, 0);
        fa = 3; fb = 20;
        inject(0, 3, 10, 4);
        inject(2, 4, 77, 9);
        send_cmd(2'b10, 0, 0, 0);
        pulse_ecc(pfa_of(0, 3, 0), 13'h1);
        repeat (20) tick();
        pulse_ecc(pfa_of(2, 4, 0), 13'h3);
        wait_done(code, got);
        chk(got && code == 2'b01 && busy, "R8 queued repair follows", busy, 1);
        wait_done(code, got);
        chk(got && code == 2'b01, "R8 second repair code", code, 1);
        chk(mem_diffs() == 0, "R8 both frames restored", mem_diffs(), 0);
        tick();

        // R8: syndrome in the final acknowledge cycle
        send_cmd(2'b01, 0, 0, 0);
        inject(1, 1, 100, 31);
        inject(3, 6, 0, 0);
        send_cmd(2'b10, 0, 0, 0);
        pulse_ecc(pfa_of(1, 1, 0), 13'h100);
        for (int i = 0; i < 2000; i++) begin
            tick();
            if (fm_req && fm_we && fm_word == 7'd100 && !fm_ack) break;
        end
        ecc_valid = 1; ecc_far = pfa_of(3, 6, 0); ecc_syndrome = 13'h7;
        tick();
        ecc_valid = 0; ecc_syndrome = 0;
        wait_done(code, got);
        chk(got && code == 2'b01 && busy, "R8 same-cycle hit kept", busy, 1);
        wait_done(code, got);
        chk(got && code == 2'b01, "R8 same-cycle second repair", code, 1);
        chk(mem_diffs() == 0, "R8 same-cycle memory restored", mem_diffs(), fa - fa);
        tick();

        // R9: command and hit in the same cycle
        send_cmd(2'b01, 0, 0, 0);
        inject(2, 7, 33, 12);
        send_cmd(2'b10, 0, 0, 0);
        cmd_valid = 1; cmd_op = 2'b01;
        ecc_valid = 1; ecc_far = pfa_of(2, 7, 0); ecc_syndrome = 13'h40;
        tick();
        cmd_valid = 0; ecc_valid = 0; ecc_syndrome = 0;
        @(negedge clk);
        chk(busy && mode_obs, "R9 repair wins over command", {busy, mode_obs}, 3);
        // R2: command while busy dropped
        tick();
        send_cmd(2'b01, 0, 0, 0);
        wait_done(code, got);
        chk(mode_obs == 1, "R2 busy command dropped", mode_obs, 1);
        chk(mem_diffs() == 0, "R9 frame restored", mem_diffs(), 0);
        tick();
        send_cmd(2'b01, 0, 0, 0);
        @(negedge clk);
        chk(!mode_obs, "R2 passive command", mode_obs, fb - fb);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule